// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous static RAM. The RAM has 18 address bits, a byte-wide data bus, and three active-low strobes: chip select, output enable and write enable. The host places one read or one write at a time through a request/ready handshake. The block then drives the strobes in a fixed order and holds each phase for a number of clock cycles. It returns a one-cycle acknowledge, which carries the read byte when the access was a read. The data bus leaves the block as a separate output value, an output-enable flag and an input value, so that the pad ring can build the tristate driver.

Every phase length is worked out at elaboration from the clock period in nanoseconds and from the chosen speed grade. Each count is the rounded-up quotient plus one cycle of margin. During a write, the block waits for the RAM to release the bus before it drives, and it never asserts output enable. The host can also hold the RAM in a low-power retention state, in which chip select stays high. After the host releases that state, the block enforces a full read-cycle recovery before it accepts the next access.

States: `ST_IDLE` (ready), `ST_RD_ACCESS` (read strobes held), `ST_WR_TURN` (write enable low, bus not yet driven), `ST_WR_DRIVE` (write data on the bus), `ST_WR_RECOVER` (strobes released), `ST_RET_SLEEP` (retention), `ST_RET_WAKE` (recovery after retention). The transitions are as follows:
- IDLE goes to RET_SLEEP on a retention request. Otherwise a request moves it to RD_ACCESS or to WR_TURN.
- RD_ACCESS returns to IDLE when its count ends.
- WR_TURN goes to WR_DRIVE, then to WR_RECOVER, then back to IDLE, each as its count ends.
- RET_SLEEP goes to RET_WAKE when the retention request drops.
- RET_WAKE returns to IDLE when its count ends.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `ram_cs_n`, `ram_oe_n` and `ram_we_n` are 1, `ram_dq_oe` is 0 and `host_ack` is 0. `host_ready` is 1 once reset has been released.
- R2: A read that is accepted at a clock edge holds `ram_cs_n`=0, `ram_oe_n`=0 and `ram_we_n`=1 for exactly RD clock cycles, starting at that edge, with `ram_addr` equal to the request address throughout. Here cyc(x) = ceil(x / CLK_NS) + 1 and RD = max(cyc(tAA), cyc(tRC)).
- R3: The read byte is sampled from `ram_dq_in` at the edge that ends the read strobes. It appears on `host_rdata` in the same cycle as a one-cycle `host_ack` pulse, which is the cycle right after the last strobe cycle.
- R4: A write that is accepted at a clock edge holds `ram_cs_n`=0 and `ram_we_n`=0 for exactly TURN + DRV cycles, with `ram_oe_n`=1 throughout. Here TURN = cyc(tRELEASE) and DRV = max(cyc(tDW), max(cyc(tWP), cyc(tAW)) − TURN).
- R5: `ram_dq_oe` rises TURN cycles after `ram_we_n` falls. It falls on the same edge at which `ram_we_n` rises. While it is 1, `ram_dq_out` equals the write byte.
- R6: After write enable rises, all strobes stay high for REC = max(1, cyc(tWC) − TURN − DRV) cycles. The one-cycle `host_ack` follows in the next cycle.
- R7: `host_ready` is 0 from the edge that accepts an access until the edge that raises `host_ack`. A `host_req` seen while `host_ready` is 0 is ignored: it starts no strobe and writes nothing.
- R8: `ram_oe_n`=0 never coincides with `ram_we_n`=0 or with `ram_dq_oe`=1. No output or write strobe is low while `ram_cs_n` is 1.
- R9: In IDLE, `lowpwr_req`=1 enters retention and takes priority over a `host_req` in the same cycle. In retention `host_ready` is 0 and `ram_cs_n` stays 1.
- R10: After `lowpwr_req` is first sampled 0 during retention, `host_ready` stays 0 for exactly WAKE = cyc(tRC) cycles, with all strobes high, and then returns to 1.
- R11: `SLOW_GRADE`=0 selects tAA=tRC=tWC=55, tWP=tAW=45, tDW=40 and tRELEASE=25 ns. `SLOW_GRADE`=1 selects 70, 70, 70, 55, 60, 40 and 30 ns. At `CLK_NS`=4 and the fast grade this gives RD=15, TURN=8, DRV=11, REC=1 and WAKE=15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, taken when host_ready is 1 |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Access address |
| host_wdata | input | 8 | Write byte |
| lowpwr_req | input | 1 | Level request for the retention state |
| host_ready | output | 1 | Block idle and able to take a request |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read byte, valid while host_ack is 1 after a read |
| ram_addr | output | 18 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_out | output | 8 | Byte for the data bus driver |
| ram_dq_oe | output | 1 | 1 = block drives the data bus |
| ram_dq_in | input | 8 | Byte seen on the data bus |

## Verification
The bench drives a request at a falling edge and counts falling-edge samples from there. A read must show RD samples of low strobes and its acknowledge at sample RD+1. A write must show its first driven sample at TURN+1 and its acknowledge at sample TURN+DRV+REC+1. After the retention request drops, the ready flag must stay low for exactly WAKE samples. Because every sample is taken half a cycle away from the edge that moves the registered outputs, each measured count lines up with the cycle counts in the requirements.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_TURN,
        ST_WR_DRIVE,
        ST_WR_RECOVER,
        ST_RET_SLEEP,
        ST_RET_WAKE
    } seq_state_t;

    // Cycles for a minimum window: rounded-up quotient plus one margin cycle
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns + 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int AW = 18,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          rd_capture,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] ram_dq_in,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_dq_out,
    output logic [DW-1:0] host_rdata
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    // Address and write byte stay frozen for the whole access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_capture) begin
            rdata_q <= ram_dq_in;
        end
    end

    assign ram_addr   = addr_q;
    assign ram_dq_out = wdata_q;
    assign host_rdata = rdata_q;

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CW       = 5,
    parameter int RD_CYC   = 15,
    parameter int TURN_CYC = 8,
    parameter int DRV_CYC  = 11,
    parameter int REC_CYC  = 1,
    parameter int WAKE_CYC = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_write,
    input  logic          lowpwr_req,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          rd_capture,
    output logic          host_ready,
    output logic          host_ack,
    output logic          cs_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          dq_oe
);

    localparam logic [CW-1:0] RD_LD   = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);
    localparam logic [CW-1:0] DRV_LD  = CW'(DRV_CYC - 1);
    localparam logic [CW-1:0] REC_LD  = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] WAKE_LD = CW'(WAKE_CYC - 1);

    seq_state_t state_q, state_d;
    logic       finish;

    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        accept     = 1'b0;
        rd_capture = 1'b0;
        finish     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (lowpwr_req) begin
                    state_d = ST_RET_SLEEP;
                end else if (host_req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (host_write) begin
                        state_d = ST_WR_TURN;
                        tmr_val = TURN_LD;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = RD_LD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    rd_capture = 1'b1;
                    finish     = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
            ST_WR_TURN: begin
                if (tmr_done) begin
                    state_d  = ST_WR_DRIVE;
                    tmr_load = 1'b1;
                    tmr_val  = DRV_LD;
                end
            end
            ST_WR_DRIVE: begin
                if (tmr_done) begin
                    state_d  = ST_WR_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = REC_LD;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_done) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_RET_SLEEP: begin
                if (!lowpwr_req) begin
                    state_d  = ST_RET_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = WAKE_LD;
                end
            end
            ST_RET_WAKE: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Strobes are registered from the next state, so the pins carry no decode glitches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n     <= 1'b1;
            oe_n     <= 1'b1;
            we_n     <= 1'b1;
            dq_oe    <= 1'b0;
            host_ack <= 1'b0;
        end else begin
            cs_n     <= !(state_d == ST_RD_ACCESS || state_d == ST_WR_TURN ||
                          state_d == ST_WR_DRIVE);
            oe_n     <= !(state_d == ST_RD_ACCESS);
            we_n     <= !(state_d == ST_WR_TURN || state_d == ST_WR_DRIVE);
            dq_oe    <= (state_d == ST_WR_DRIVE);
            host_ack <= finish;
        end
    end

    assign host_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS     = 4,
    parameter bit SLOW_GRADE = 1'b0,
    parameter int AW         = 18,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_write,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          lowpwr_req,
    output logic          host_ready,
    output logic          host_ack,
    output logic [DW-1:0] host_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_cs_n,
    output logic          ram_oe_n,
    output logic          ram_we_n,
    output logic [DW-1:0] ram_dq_out,
    output logic          ram_dq_oe,
    input  logic [DW-1:0] ram_dq_in
);

    // Nanosecond minimums of the selected speed grade
    localparam int T_ACC_NS = SLOW_GRADE ? 70 : 55;
    localparam int T_RC_NS  = SLOW_GRADE ? 70 : 55;
    localparam int T_WC_NS  = SLOW_GRADE ? 70 : 55;
    localparam int T_WP_NS  = SLOW_GRADE ? 55 : 45;
    localparam int T_AW_NS  = SLOW_GRADE ? 60 : 45;
    localparam int T_DS_NS  = 40;
    localparam int T_REL_NS = SLOW_GRADE ? 30 : 25;

    localparam int RD_CYC   = imax(ns_to_cycles(T_ACC_NS, CLK_NS),
                                   ns_to_cycles(T_RC_NS, CLK_NS));
    localparam int TURN_CYC = ns_to_cycles(T_REL_NS, CLK_NS);
    localparam int PULSE_MIN = imax(ns_to_cycles(T_WP_NS, CLK_NS),
                                    ns_to_cycles(T_AW_NS, CLK_NS));
    localparam int DRV_CYC  = imax(ns_to_cycles(T_DS_NS, CLK_NS),
                                   PULSE_MIN - TURN_CYC);
    localparam int REC_CYC  = imax(1, ns_to_cycles(T_WC_NS, CLK_NS) - TURN_CYC - DRV_CYC);
    localparam int WAKE_CYC = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int MAX_CYC  = imax(imax(RD_CYC, WAKE_CYC),
                                   imax(imax(TURN_CYC, DRV_CYC), REC_CYC));
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          accept;
    logic          rd_capture;

    sram_seq_fsm #(
        .CW       (CW),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .DRV_CYC  (DRV_CYC),
        .REC_CYC  (REC_CYC),
        .WAKE_CYC (WAKE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_write (host_write),
        .lowpwr_req (lowpwr_req),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .rd_capture (rd_capture),
        .host_ready (host_ready),
        .host_ack   (host_ack),
        .cs_n       (ram_cs_n),
        .oe_n       (ram_oe_n),
        .we_n       (ram_we_n),
        .dq_oe      (ram_dq_oe)
    );

    sram_phase_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_data_path #(
        .AW (AW),
        .DW (DW)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .rd_capture (rd_capture),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .ram_dq_in  (ram_dq_in),
        .ram_addr   (ram_addr),
        .ram_dq_out (ram_dq_out),
        .host_rdata (host_rdata)
    );

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_req,
    input logic          lowpwr_req,
    input logic          host_ready,
    input logic          host_ack,
    input logic [AW-1:0] ram_addr,
    input logic          ram_cs_n,
    input logic          ram_oe_n,
    input logic          ram_we_n,
    input logic          ram_dq_oe
);

    // R8
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (ram_we_n && !ram_dq_oe));

    // R8
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_oe_n || !ram_we_n) |-> !ram_cs_n);

    // R5
    drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> (!ram_we_n && !ram_cs_n));

    // R5
    drive_after_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dq_oe) |-> $past(!ram_we_n));

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));

    // R7
    start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_req && !lowpwr_req) |=> (!ram_cs_n && !host_ready));

    // R9
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && lowpwr_req) |=> (!host_ready && ram_cs_n));

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/async_sram_ctrl_test.sv
module async_sram_ctrl_test;

    localparam int TCK = 4;

    function automatic int cy(input int ns);
        return ns / TCK + ((ns % TCK) != 0 ? 1 : 0) + 1;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R11 fast grade expected counts
    localparam int E_RD   = 15;
    localparam int E_TURN = 8;
    localparam int E_DRV  = 11;
    localparam int E_REC  = 1;
    localparam int E_WAKE = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [17:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        lowpwr_req = 1'b0;
    logic        host_ready;
    logic        host_ack;
    logic [7:0]  host_rdata;
    logic [17:0] ram_addr;
    logic        ram_cs_n;
    logic        ram_oe_n;
    logic        ram_we_n;
    logic [7:0]  ram_dq_out;
    logic        ram_dq_oe;
    logic [7:0]  ram_q = 8'hA5;

    int total = 0;
    int bad = 0;
    int contention = 0;
    bit finished = 1'b0;

    logic [7:0] model [int];
    logic [7:0] score [int];

    always #(TCK / 2) clk = ~clk;

    async_sram_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .lowpwr_req (lowpwr_req),
        .host_ready (host_ready),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .ram_addr   (ram_addr),
        .ram_cs_n   (ram_cs_n),
        .ram_oe_n   (ram_oe_n),
        .ram_we_n   (ram_we_n),
        .ram_dq_out (ram_dq_out),
        .ram_dq_oe  (ram_dq_oe),
        .ram_dq_in  (ram_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [17:0] a);
        if (model.exists(int'(a))) return model[int'(a)];
        return 8'h00;
    endfunction

    // Behavioural RAM: answers reads, commits writes when write enable rises
    logic        prev_we_n = 1'b1;
    logic [7:0]  seen_data = '0;
    int          drive_samples = 0;
    always @(negedge clk) begin
        if (!ram_oe_n && (ram_dq_oe || !ram_we_n)) contention++;
        if (!ram_cs_n && !ram_oe_n && ram_we_n) ram_q = model_read(ram_addr);
        else ram_q = 8'hA5;
        if (rst_n && !ram_we_n && ram_dq_oe) begin
            seen_data = ram_dq_out;
            drive_samples++;
        end
        if (rst_n && !prev_we_n && ram_we_n) begin
            chk(drive_samples * TCK >= 40, "R5 data setup before end of write",
                drive_samples * TCK, 40);
            model[int'(ram_addr)] = seen_data;
            drive_samples = 0;
        end
        prev_we_n = ram_we_n;
    end

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        int cs_low = 0, we_low = 0, oe_low = 0, drv = 0, first_drv = 0;
        int ack_k = 0, rdy_hi = 0, bad_data = 0;
        host_req = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            if (k == 1) host_req = 1'b0;
            if (host_ack) begin ack_k = k; break; end
            if (host_ready) rdy_hi++;
            if (!ram_cs_n) cs_low++;
            if (!ram_we_n) we_low++;
            if (!ram_oe_n) oe_low++;
            if (ram_dq_oe) begin
                drv++;
                if (first_drv == 0) first_drv = k;
                if (ram_dq_out != d) bad_data++;
            end
        end
        score[int'(a)] = d;
        chk(we_low == E_TURN + E_DRV, "R4 R11 write enable low cycles", we_low, E_TURN + E_DRV);
        chk(cs_low == E_TURN + E_DRV, "R4 R6 chip select low cycles", cs_low, E_TURN + E_DRV);
        chk(oe_low == 0, "R4 output enable during write", oe_low, 0);
        chk(first_drv == E_TURN + 1, "R5 first driven sample", first_drv, E_TURN + 1);
        chk(drv == E_DRV, "R5 driven cycles", drv, E_DRV);
        chk(bad_data == 0, "R5 driven byte", bad_data, 0);
        chk(ack_k == E_TURN + E_DRV + E_REC + 1, "R6 write ack sample", ack_k,
            E_TURN + E_DRV + E_REC + 1);
        chk(rdy_hi == 0, "R7 ready while busy", rdy_hi, 0);
    endtask

    task automatic do_read(input logic [17:0] a, input bit poke);
        int cs_low = 0, oe_low = 0, we_low = 0, ack_k = 0, rdy_hi = 0, bad_addr = 0;
        logic [7:0] exp_d;
        host_req = 1'b1; host_write = 1'b0; host_addr = a;
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            if (k == 1) host_req = 1'b0;
            if (poke && k == 3) begin
                host_req = 1'b1; host_write = 1'b1;
                host_addr = a ^ 18'h00100; host_wdata = 8'hEE;
            end
            if (poke && k == 4) host_req = 1'b0;
            if (host_ack) begin ack_k = k; break; end
            if (host_ready) rdy_hi++;
            if (!ram_cs_n) cs_low++;
            if (!ram_oe_n) oe_low++;
            if (!ram_we_n) we_low++;
            if (!ram_cs_n && ram_addr != a) bad_addr++;
        end
        exp_d = score.exists(int'(a)) ? score[int'(a)] : 8'h00;
        chk(cs_low == E_RD, "R2 R11 read chip select cycles", cs_low, E_RD);
        chk(oe_low == E_RD, "R2 read output enable cycles", oe_low, E_RD);
        chk(we_low == 0, "R2 write enable during read", we_low, 0);
        chk(bad_addr == 0, "R2 address during read", bad_addr, 0);
        chk(ack_k == E_RD + 1, "R3 read ack sample", ack_k, E_RD + 1);
        chk(host_rdata == exp_d, "R3 read byte", int'(host_rdata), int'(exp_d));
        chk(rdy_hi == 0, "R7 ready while busy", rdy_hi, 0);
    endtask

    initial begin
        int cs_seen, rdy_lo, strobes, first_hi;
        logic [31:0] lfsr;
        logic [17:0] a;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(ram_cs_n && ram_oe_n && ram_we_n, "R1 strobes in reset", 0, 1);
        chk(!ram_dq_oe && !host_ack, "R1 drive and ack in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready == 1'b1, "R1 ready after reset", int'(host_ready), 1);
        chk(ram_cs_n && ram_oe_n && ram_we_n && !ram_dq_oe, "R1 strobes after reset", 0, 1);
        chk(cy(55) == E_RD && cy(25) == E_TURN &&
            mx(cy(40), cy(45) - E_TURN) == E_DRV &&
            mx(1, cy(55) - E_TURN - E_DRV) == E_REC, "R11 derived counts", 0, 0);

        // Address sweep: zero, each single bit, all ones
        for (int i = 0; i < 20; i++) begin
            a = (i == 0) ? 18'h0 : (i == 19) ? 18'h3FFFF : 18'(1) << (i - 1);
            do_write(a, 8'((i * 53 + 7) & 255));
        end
        for (int i = 0; i < 20; i++) begin
            a = (i == 0) ? 18'h0 : (i == 19) ? 18'h3FFFF : 18'(1) << (i - 1);
            do_read(a, 1'b0);
        end

        // R7 request while busy is ignored
        do_read(18'h00004, 1'b1);
        cs_seen = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (!ram_cs_n) cs_seen++;
        end
        chk(cs_seen == 0, "R7 no access from busy request", cs_seen, 0);
        do_read(18'h00104, 1'b0);

        // Mixed traffic on a small address window
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 160; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = {lfsr[9:8], 10'h0, lfsr[5:0]};
            if (lfsr[12]) do_write(a, lfsr[27:20]);
            else do_read(a, 1'b0);
        end

        // R9 retention entry wins over a request in the same cycle
        lowpwr_req = 1'b1; host_req = 1'b1; host_write = 1'b0; host_addr = 18'h5;
        cs_seen = 0; rdy_lo = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!ram_cs_n) cs_seen++;
            if (!host_ready) rdy_lo++;
        end
        chk(cs_seen == 0, "R9 chip select in retention", cs_seen, 0);
        chk(rdy_lo == 6, "R9 ready in retention", rdy_lo, 6);
        // R10 recovery after retention
        lowpwr_req = 1'b0; host_req = 1'b0;
        rdy_lo = 0; strobes = 0; first_hi = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (host_ready) begin first_hi = k; break; end
            rdy_lo++;
            if (!ram_cs_n || !ram_oe_n || !ram_we_n) strobes++;
        end
        chk(rdy_lo == E_WAKE, "R10 recovery cycles", rdy_lo, E_WAKE);
        chk(first_hi == E_WAKE + 1, "R10 ready return sample", first_hi, E_WAKE + 1);
        chk(strobes == 0, "R10 strobes during recovery", strobes, 0);
        do_read(18'h00002, 1'b0);

        chk(contention == 0, "R8 bus contention samples", contention, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule